// File: doc/BRIEF.md
# Secondary Processor Boot Release Table

A memory-mapped table that holds one 32-byte boot record for each of up to 32 processors. Boot software running on the primary processor fills in a secondary's record over a simple bus slave port, using 1-, 2- or 4-byte accesses. When the record's 64-bit start address has its low hold bit cleared, the block issues a release for that processor.

A release is a one-cycle pulse on a one-hot vector, with three registered values presented in the same cycle: the start offset inside a 64 MiB window, the window base, and the record's first-argument value. On release the record's processor ID word is replaced by the processor's own ID, taken from an input. Record 0 belongs to the primary processor and cannot be written. Records at or above the number of processors present cannot be written either.

Record layout, by byte offset in the record: bytes 0–7 hold the start address, with bit 0 of byte 7 as the hold flag. Bytes 8–15 hold the first-argument value. Bytes 20–23 hold the processor ID. Bytes 16–19 and 24–31 are spare storage. Multi-byte fields are big-endian, so the lowest address holds the most significant byte. The record index is the bus address divided by 32.

Top module: `boot_release_table`

## Requirements
- R1: After reset, record i holds start address 1, first-argument value i and processor ID i. All other bytes are 0.
- R2: A read of size 1, 2 or 4 at any byte address returns the stored bytes in big-endian order, right-justified in `rsp_rdata`, with `rsp_valid` high in the cycle after the request.
- R3: A write of size 1, 2 or 4 changes only the addressed bytes. The least significant `size` bytes of `req_wdata` are stored big-endian from `req_addr` upward.
- R4: A write whose record index is 0 changes nothing and causes no release.
- R5: A write whose record index is not below `num_present` changes nothing and causes no release.
- R6: After an accepted write, if bit 0 of the updated start address is 0, that processor's bit of `rel_pulse` is high for exactly the cycle two clock edges after the write was sampled. At most one bit of `rel_pulse` is ever high.
- R7: In the release cycle, `rel_offset` equals the start address masked to bits 25:0, `rel_base` equals the start address with bits 25:0 cleared, and `rel_arg` equals bytes 8–15 of the record.
- R8: On release, bytes 20–23 of the record become `cpu_id[32*i +: 32]` of the released processor i.
- R9: A request whose size is not 1, 2 or 4 raises `rsp_err` in the next cycle and writes nothing.
- R10: An accepted write that leaves the hold bit at 1 causes no release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address in the table |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-justified |
| num_present | input | 6 | Number of processors present |
| cpu_id | input | 1024 | Own ID value of each processor, 32 bits each |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-justified |
| rsp_err | output | 1 | Unsupported access size |
| rel_pulse | output | 32 | One-hot release pulse |
| rel_offset | output | 64 | Start offset within the 64 MiB window |
| rel_base | output | 64 | Window base address |
| rel_arg | output | 64 | First-argument value |

## Verification
The assertions assume that `num_present` and `cpu_id` stay stable while requests are in flight. They also assume that requests arrive as single-cycle strobes, so each response or release can be traced back to one earlier request. The stimulus sets `num_present` and `cpu_id` once, before reset is released, and never changes them. Each request is driven for exactly one clock and then cleared before the outputs are sampled. Accesses that would cross a record boundary are not generated, because the discard and release decisions use only the record of the first byte.

// File: rtl/boot_release_table.sv
module boot_release_table #(
  parameter int NPROC    = 32,
  parameter int REC_B    = 32,
  parameter int WIN_BITS = 26
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [9:0]            req_addr,
  input  logic [2:0]            req_size,
  input  logic [31:0]           req_wdata,
  input  logic [5:0]            num_present,
  input  logic [NPROC*32-1:0]   cpu_id,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  output logic                  rsp_err,
  output logic [NPROC-1:0]      rel_pulse,
  output logic [63:0]           rel_offset,
  output logic [63:0]           rel_base,
  output logic [63:0]           rel_arg
);
  localparam int BYTES = NPROC * REC_B;
  localparam int OB    = $clog2(REC_B);
  localparam int IB    = $clog2(NPROC);
  localparam logic [63:0] WIN_MASK = (64'd1 << WIN_BITS) - 64'd1;

  logic [7:0] mem [BYTES];

  logic [IB-1:0] idx;
  logic          size_ok, wr_ok, pend;
  logic [IB-1:0] pend_idx;
  logic [31:0]   wsh, rd_all;
  logic [63:0]   start, arg;

  assign idx     = req_addr[OB +: IB];
  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign wr_ok   = req_valid && req_write && size_ok && (idx != '0) &&
                   ({1'b0, idx} < num_present);
  assign wsh     = req_wdata << (8 * (4 - req_size));
  assign rd_all  = {mem[req_addr], mem[req_addr + 10'd1], mem[req_addr + 10'd2],
                    mem[req_addr + 10'd3]};

  always_comb begin
    start = '0;
    arg   = '0;
    for (int k = 0; k < 8; k++) begin
      start[63-8*k -: 8] = mem[{pend_idx, OB'(k)}];
      arg[63-8*k -: 8]   = mem[{pend_idx, OB'(k + 8)}];
    end
  end

  function automatic logic [7:0] reset_byte(int i);
    int off;
    int rec;
    off = i % REC_B;
    rec = i / REC_B;
    if (off == 7)       return 8'd1;
    else if (off == 15) return 8'(rec);
    else if (off == 23) return 8'(rec);
    else                return 8'd0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= reset_byte(i);
      pend       <= 1'b0;
      pend_idx   <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
      rel_pulse  <= '0;
      rel_offset <= '0;
      rel_base   <= '0;
      rel_arg    <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write && size_ok;
      rsp_err   <= req_valid && !size_ok;
      if (req_valid && !req_write && size_ok)
        rsp_rdata <= rd_all >> (8 * (4 - req_size));
      pend     <= wr_ok;
      pend_idx <= idx;
      if (wr_ok)
        for (int k = 0; k < 4; k++)
          if (k < int'(req_size)) mem[req_addr + 10'(k)] <= wsh[31-8*k -: 8];
      rel_pulse <= '0;
      if (pend && !start[0]) begin
        rel_pulse[pend_idx] <= 1'b1;
        rel_offset <= start & WIN_MASK;
        rel_base   <= start & ~WIN_MASK;
        rel_arg    <= arg;
        for (int k = 0; k < 4; k++)
          mem[{pend_idx, OB'(20 + k)}] <= cpu_id[pend_idx*32 + 31 - 8*k -: 8];
      end
    end
  end

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rel_pulse));
  p_no_primary_r4: assert property (@(posedge clk) disable iff (!rst_n) !rel_pulse[0]);
  p_rel_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> $past(req_valid && req_write, 2));
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid));
  p_rsp_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> ((rel_offset & rel_base) == 64'd0));
endmodule

// File: tb/test_boot_release_table.sv
module test_boot_release_table;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [9:0] req_addr = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic [5:0] num_present = 6'd8;
  logic [1023:0] cpu_id;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [31:0] rel_pulse;
  logic [63:0] rel_offset, rel_base, rel_arg;

  int n_chk = 0, n_fail = 0;
  logic [31:0] s_pulse;
  logic [63:0] s_off, s_base, s_arg;
  logic [31:0] s_rd;
  logic s_err;

  always #2.5 clk = ~clk;

  boot_release_table i_boot_release_table (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .num_present(num_present), .cpu_id(cpu_id), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rel_pulse(rel_pulse),
    .rel_offset(rel_offset), .rel_base(rel_base), .rel_arg(rel_arg));

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [2:0]  size;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd167, 3'd1, 32'h0000_0001},
    '{1'b0, 10'd172, 3'd4, 32'h0000_0005},
    '{1'b0, 10'd1012, 3'd4, 32'h0000_001F},
    '{1'b0, 10'd70, 3'd2, 32'h0000_0001},
    '{1'b0, 10'd0, 3'd4, 32'h0000_0000},
    '{1'b0, 10'd310, 3'd2, 32'h0000_0009},
    '{1'b1, 10'd136, 3'd1, 32'h0000_00AB},
    '{1'b0, 10'd136, 3'd4, 32'hAB00_0000},
    '{1'b1, 10'd138, 3'd2, 32'h0000_BEEF},
    '{1'b0, 10'd136, 3'd4, 32'hAB00_BEEF}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [9:0] a, logic [2:0] sz, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    s_err = rsp_err;
    @(negedge clk);
    s_pulse = rel_pulse; s_off = rel_offset; s_base = rel_base; s_arg = rel_arg;
  endtask

  task automatic do_read(logic [9:0] a, logic [2:0] sz);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 0;
    s_rd = rsp_valid ? rsp_rdata : 32'hDEAD_DEAD;
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) cpu_id[32*k +: 32] = 32'hA000 + k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R6 reset pulse", rel_pulse, 0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) begin
        do_write(VECS[v].addr, VECS[v].size, VECS[v].data);
        check("R10 no release on hold", s_pulse, 0);
      end else begin
        do_read(VECS[v].addr, VECS[v].size);
        check(v < 6 ? "R1/R2 reset read" : "R3 lane write", s_rd, VECS[v].data);
      end
    end
    do_read(10'd140, 3'd4);
    check("R3 untouched bytes", s_rd, 32'h4);

    // R10: high word written, hold bit still 1
    do_write(10'd96, 3'd4, 32'h0000_0001);
    check("R10 high word no release", s_pulse, 0);
    // R6/R7/R8
    do_write(10'd100, 3'd4, 32'h1234_5678);
    check("R6 pulse", s_pulse, 32'h8);
    check("R7 offset", s_off, 64'h0000_0000_0234_5678);
    check("R7 base", s_base, 64'h0000_0001_1000_0000);
    check("R7 arg", s_arg, 64'd3);
    @(negedge clk);
    check("R6 single cycle", rel_pulse, 0);
    do_read(10'd116, 3'd4);
    check("R8 id overwrite", s_rd, 32'hA003);

    do_write(10'd172, 3'd4, 32'hCAFE_F00D);
    check("R10 arg write", s_pulse, 0);
    do_write(10'd164, 3'd4, 32'hFC00_0000);
    check("R6 pulse rec5", s_pulse, 32'h20);
    check("R7 offset rec5", s_off, 64'h0);
    check("R7 base rec5", s_base, 64'hFC00_0000);
    check("R7 arg rec5", s_arg, 64'hCAFE_F00D);

    do_write(10'd199, 3'd1, 32'h40);
    check("R6 byte release", s_pulse, 32'h40);
    check("R7 byte offset", s_off, 64'h40);

    // R4
    do_write(10'd4, 3'd4, 32'h0);
    check("R4 no pulse", s_pulse, 0);
    do_read(10'd7, 3'd1);
    check("R4 unchanged", s_rd, 32'h1);
    // R5
    do_write(10'd324, 3'd4, 32'h0);
    check("R5 no pulse", s_pulse, 0);
    do_read(10'd327, 3'd1);
    check("R5 unchanged", s_rd, 32'h1);
    // R9
    do_write(10'd228, 3'd3, 32'h0);
    check("R9 err", s_err, 1);
    check("R9 no pulse", s_pulse, 0);
    do_read(10'd228, 3'd4);
    check("R9 unchanged", s_rd, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule